// File: doc/BRIEF.md
# Ethernet Receive Frame Checker

This block sits behind a receive MAC's byte deserializer. Bytes of one frame arrive one per cycle, qualified by a valid strobe, with markers on the first and last byte. The block runs a CRC-32 over every byte of the frame, FCS included. It counts the length and classifies the frame when the last byte arrives. The verdict is posted as a status byte for the host.

Data bytes go on to a downstream byte FIFO through a four-stage delay line. A byte is released only after four later bytes have arrived, so the trailing FCS never reaches the FIFO. The last released byte carries an end marker.

A status byte that is posted but not yet read blocks new frames. A frame that starts while the status is unread is dropped whole, and the status stays as it was. A single-cycle read strobe marks the status as read. Frames longer than the maximum length are cut off at the FIFO input.

Top module: `rx_frame_checker`

## Requirements
- R1: After reset `rx_status` is 0x80, the read flag in bit 7 is set, and `fifo_valid` is low.
- R2: For a frame of at least MIN_LEN (64) and at most MAX_LEN bytes, the CRC register is preset to all ones and updated LSB first with the reflected polynomial 0xEDB88320. If that register equals 0xDEBB20E3 after the last byte, the frame is good. The posted status is then 0x30: good in bit 5, end in bit 4.
- R3: A frame of MIN_LEN to MAX_LEN bytes whose CRC register ends at any other value posts 0x12: end in bit 4, CRC error in bit 1.
- R4: A frame shorter than MIN_LEN bytes, FCS counted, posts 0x18 (end in bit 4, short in bit 3), whatever its CRC.
- R5: A frame longer than MAX_LEN bytes posts 0x11 (end in bit 4, overflow in bit 0). The block forwards only its first MAX_LEN-4 bytes.
- R6: For a frame of at most MAX_LEN bytes, every byte except the last four goes to the FIFO, in arrival order. Byte k appears on `fifo_data` with `fifo_valid` one cycle after byte k+4 is taken. A frame of four bytes or fewer forwards nothing.
- R7: `fifo_eof` is high with exactly one forwarded byte per frame: the last one forwarded.
- R8: A frame that starts while bit 7 of `rx_status` is clear forwards no byte and leaves `rx_status` unchanged.
- R9: Posting clears bit 7. A `stat_read` pulse sets bit 7 one cycle later. If a post and a read fall in the same cycle, the post wins and bit 7 stays clear.
- R10: Valid bytes outside a frame are ignored, meaning bytes after an end marker and before the next start marker. So are idle cycles inside a frame, where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_data | input | 8 | Received byte |
| stat_read | input | 1 | Host has read the status (one-cycle pulse) |
| fifo_valid | output | 1 | Forwarded byte valid |
| fifo_data | output | 8 | Forwarded byte |
| fifo_eof | output | 1 | Forwarded byte is the last of the frame |
| rx_status | output | 8 | Status byte: bit 7 read, 5 good, 4 end, 3 short, 1 CRC error, 0 overflow |

## Verification
The assertions assume that frames do not overlap and that start and end markers appear only on valid bytes. They also assume the host raises `stat_read` for one cycle at a time. The bench drives each frame as one contiguous run of markers, with idle cycles only between bytes of the same frame. It issues reads only while no frame byte is in flight, except for one deliberate case where the read coincides with an end marker. Frame lengths are swept from one byte to past the maximum, with and without a corrupted byte, under a reduced MAX_LEN.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
   localparam int unsigned CRC_W = 32;
   localparam logic [CRC_W-1:0] CRC_POLY    = 32'hEDB88320;
   localparam logic [CRC_W-1:0] CRC_PRESET  = 32'hFFFFFFFF;
   localparam logic [CRC_W-1:0] CRC_RESIDUE = 32'hDEBB20E3;

   // status byte layout
   localparam int unsigned ST_READ  = 7;
   localparam int unsigned ST_GOOD  = 5;
   localparam int unsigned ST_END   = 4;
   localparam int unsigned ST_SHORT = 3;
   localparam int unsigned ST_CRC   = 1;
   localparam int unsigned ST_OVF   = 0;
   localparam logic [7:0]  ST_RESET = 8'h80;

   typedef struct packed {
      logic good;
      logic short_f;
      logic crc_bad;
      logic ovf;
   } verdict_t;
endpackage

// File: rtl/rxfc_crc_byte.sv
module rxfc_crc_byte
   import rxfc_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic [CRC_W-1:0] crc_in,
   input  logic [DW-1:0]    data,
   output logic [CRC_W-1:0] crc_out
);
   logic [DW:0][CRC_W-1:0] stage;

   assign stage[0] = crc_in;
   for (genvar b = 0; b < DW; b++) begin : g_bit
      assign stage[b+1] = (stage[b][0] ^ data[b]) ?
                          ((stage[b] >> 1) ^ CRC_POLY) : (stage[b] >> 1);
   end
   assign crc_out = stage[DW];
endmodule

// File: rtl/rxfc_crc_acc.sv
module rxfc_crc_acc
   import rxfc_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             advance,
   input  logic [DW-1:0]    data,
   output logic [CRC_W-1:0] crc_nx
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] seed;

   assign seed = start ? CRC_PRESET : crc_q;

   rxfc_crc_byte #(.DW(DW)) u_step (
      .crc_in (seed),
      .data   (data),
      .crc_out(crc_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       crc_q <= CRC_PRESET;
      else if (advance) crc_q <= crc_nx;
   end
endmodule

// File: rtl/rxfc_strip.sv
module rxfc_strip #(
   parameter int unsigned DW   = 8,
   parameter int unsigned TAIL = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift,
   input  logic          fwd,
   input  logic          mark,
   input  logic [DW-1:0] din,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic          out_eof
);
   logic [TAIL-1:0][DW-1:0] line;

   if (TAIL == 1) begin : g_single
      always_ff @(posedge clk) if (shift) line <= din;
   end else begin : g_chain
      always_ff @(posedge clk) if (shift) line <= {line[TAIL-2:0], din};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_eof   <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= shift && fwd;
         out_eof   <= shift && fwd && mark;
         if (shift && fwd) out_data <= line[TAIL-1];
      end
   end
endmodule

// File: rtl/rxfc_status.sv
module rxfc_status
   import rxfc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     post,
   input  verdict_t verdict,
   input  logic     read,
   output logic [7:0] status
);
   logic [7:0] fresh;

   always_comb begin
      fresh           = '0;
      fresh[ST_END]   = 1'b1;
      fresh[ST_GOOD]  = verdict.good;
      fresh[ST_SHORT] = verdict.short_f;
      fresh[ST_CRC]   = verdict.crc_bad;
      fresh[ST_OVF]   = verdict.ovf;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    status <= ST_RESET;
      else if (post) status <= fresh;
      else if (read) status[ST_READ] <= 1'b1;
   end
endmodule

// File: rtl/rx_frame_checker.sv
module rx_frame_checker
   import rxfc_pkg::*;
#(
   parameter int unsigned DW        = 8,
   parameter int unsigned MIN_LEN   = 64,
   parameter int unsigned MAX_LEN   = 1518,
   parameter int unsigned FCS_BYTES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sop,
   input  logic          in_eop,
   input  logic [DW-1:0] in_data,
   input  logic          stat_read,
   output logic          fifo_valid,
   output logic [DW-1:0] fifo_data,
   output logic          fifo_eof,
   output logic [7:0]    rx_status
);
   localparam int unsigned CW = $clog2(MAX_LEN + 1);
   localparam logic [CW-1:0] IDX_MAX   = CW'(MAX_LEN);
   localparam logic [CW-1:0] IDX_SHORT = CW'(MIN_LEN - 1);
   localparam logic [CW-1:0] IDX_TAIL  = CW'(FCS_BYTES);
   localparam logic [CW-1:0] IDX_LAST  = CW'(MAX_LEN - 1);

   initial begin
      assert (MIN_LEN > FCS_BYTES) else $fatal(1, "MIN_LEN must exceed FCS_BYTES");
      assert (MAX_LEN > MIN_LEN)   else $fatal(1, "MAX_LEN must exceed MIN_LEN");
      assert (FCS_BYTES >= 1)      else $fatal(1, "FCS_BYTES must be at least 1");
      assert (DW == 8)             else $fatal(1, "byte stream expected");
   end

   logic          in_frame;
   logic          accept_q;
   logic [CW-1:0] idx_q;
   logic [CW-1:0] idx_cur;
   logic          take, accept_now, shift, fwd, mark, post;
   logic [CRC_W-1:0] crc_nx;
   verdict_t      verdict;

   assign take       = in_valid && (in_sop || in_frame);
   assign accept_now = in_sop ? rx_status[ST_READ] : accept_q;
   assign idx_cur    = in_sop ? '0 : idx_q;
   assign shift      = take && accept_now;
   assign fwd        = (idx_cur >= IDX_TAIL) && (idx_cur < IDX_MAX);
   assign mark       = in_eop || (idx_cur == IDX_LAST);
   assign post       = take && in_eop && accept_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         accept_q <= 1'b0;
         idx_q    <= '0;
      end else if (take) begin
         in_frame <= !in_eop;
         if (in_sop) accept_q <= rx_status[ST_READ];
         idx_q    <= (idx_cur == IDX_MAX) ? IDX_MAX : idx_cur + 1'b1;
      end
   end

   always_comb begin
      verdict.short_f = idx_cur < IDX_SHORT;
      verdict.ovf     = !verdict.short_f && (idx_cur >= IDX_MAX);
      verdict.crc_bad = !verdict.short_f && !verdict.ovf && (crc_nx != CRC_RESIDUE);
      verdict.good    = !verdict.short_f && !verdict.ovf && !verdict.crc_bad;
   end

   rxfc_crc_acc #(.DW(DW)) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (in_sop),
      .advance(take),
      .data   (in_data),
      .crc_nx (crc_nx)
   );

   rxfc_strip #(.DW(DW), .TAIL(FCS_BYTES)) u_strip (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift    (shift),
      .fwd      (fwd),
      .mark     (mark),
      .din      (in_data),
      .out_valid(fifo_valid),
      .out_data (fifo_data),
      .out_eof  (fifo_eof)
   );

   rxfc_status u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .post   (post),
      .verdict(verdict),
      .read   (stat_read),
      .status (rx_status)
   );
endmodule

// File: rtl/rx_frame_checker_sva.sv
module rx_frame_checker_sva (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_sop,
   input logic       in_eop,
   input logic       stat_read,
   input logic       fifo_valid,
   input logic       fifo_eof,
   input logic [7:0] rx_status
);
   // R2 R3 R4 R5: a fresh post has the end bit and exactly one cause
   assert_post_single_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_status[7]) |-> (rx_status[4] && !rx_status[6] && !rx_status[2] &&
         $countones({rx_status[5], rx_status[3], rx_status[1], rx_status[0]}) == 1));

   // R8: unread status holds until the host reads it
   assert_unread_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_status[7] && !stat_read) |=> $stable(rx_status));

   // R7: the end marker only accompanies a forwarded byte
   assert_eof_with_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_eof |-> fifo_valid);

   // R6: the first byte of a frame is never released at once
   assert_first_byte_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop) |=> !fifo_valid);

   // R9: a read without a coinciding frame end sets the read flag
   assert_read_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_read && !(in_valid && in_eop)) |=> rx_status[7]);
endmodule

bind rx_frame_checker rx_frame_checker_sva u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_sop    (in_sop),
   .in_eop    (in_eop),
   .stat_read (stat_read),
   .fifo_valid(fifo_valid),
   .fifo_eof  (fifo_eof),
   .rx_status (rx_status)
);

// File: tb/rx_frame_checker_test.sv
`timescale 1ns/1ps
module rx_frame_checker_test;
   localparam int MAXL = 120;
   localparam int MINL = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, stat_read = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       fifo_valid, fifo_eof;
   logic [7:0] fifo_data, rx_status;

   always #2.5 clk = ~clk;

   rx_frame_checker #(.MIN_LEN(MINL), .MAX_LEN(MAXL)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .in_data(in_data), .stat_read(stat_read),
      .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_eof(fifo_eof),
      .rx_status(rx_status));

   int total = 0, fails = 0;
   logic [7:0] frame [0:255];
   logic [7:0] cap [0:255];
   int cap_n = 0, eof_n = 0, eof_pos = -1;

   // sample one ns after each rising edge
   always @(posedge clk) begin
      #1;
      if (rst_n && fifo_valid) begin
         if (cap_n < 256) cap[cap_n] = fifo_data;
         if (fifo_eof) begin eof_n++; eof_pos = cap_n; end
         cap_n++;
      end
   end

   task automatic check(input bit ok, input string req, input int got, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r = c;
      for (int b = 0; b < 8; b++)
         r = ((r[0] ^ d[b]) != 1'b0) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
      return r;
   endfunction

   task automatic build(input int len, input bit corrupt, input int seed);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int i = 0; i < len; i++) frame[i] = 8'((len * 7 + i * 13 + seed) & 255);
      if (len >= 5) begin
         for (int i = 0; i < len - 4; i++) c = crc_upd(c, frame[i]);
         c = ~c;
         for (int k = 0; k < 4; k++) frame[len - 4 + k] = c[8*k +: 8];
      end
      if (corrupt) frame[len / 2] = frame[len / 2] ^ 8'h04;
   endtask

   task automatic clear_cap();
      cap_n = 0; eof_n = 0; eof_pos = -1;
   endtask

   task automatic do_read();
      stat_read = 1'b1;
      @(negedge clk);
      stat_read = 1'b0;
      @(negedge clk);
   endtask

   // drive a built frame; gaps inserts an idle cycle after every third byte
   task automatic drive(input int len, input bit gaps, input bit read_at_end);
      for (int i = 0; i < len; i++) begin
         in_valid = 1'b1;
         in_sop   = (i == 0);
         in_eop   = (i == len - 1);
         in_data  = frame[i];
         stat_read = read_at_end && (i == len - 1);
         @(negedge clk);
         in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; stat_read = 1'b0;
         if (gaps && (i % 3 == 2)) @(negedge clk);
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic run_checked(input int len, input bit corrupt, input bit gaps);
      logic [7:0] exp_st;
      int exp_n;
      bit data_ok = 1'b1;
      build(len, corrupt, len + 3 * int'(corrupt));
      clear_cap();
      drive(len, gaps, 1'b0);
      if (len < MINL)      exp_st = 8'h18;   // R4
      else if (len > MAXL) exp_st = 8'h11;   // R5
      else if (corrupt)    exp_st = 8'h12;   // R3
      else                 exp_st = 8'h30;   // R2
      check(rx_status == exp_st, "R2/R3/R4/R5 status", rx_status, exp_st);
      exp_n = (len <= 4) ? 0 : ((len - 4 > MAXL - 4) ? MAXL - 4 : len - 4);
      check(cap_n == exp_n, "R6/R5 forwarded count", cap_n, exp_n);
      for (int i = 0; i < exp_n && i < cap_n; i++)
         if (cap[i] !== frame[i]) data_ok = 1'b0;
      check(data_ok, "R6 forwarded data", 0, 1);
      if (exp_n > 0) check(eof_n == 1 && eof_pos == exp_n - 1, "R7 end marker", eof_pos, exp_n - 1);
      else           check(eof_n == 0, "R7 no end marker", eof_n, 0);
      do_read();
      check(rx_status[7] == 1'b1, "R9 read sets flag", rx_status[7], 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      logic [7:0] held;
      repeat (4) @(negedge clk);
      // R1 reset state
      check(rx_status == 8'h80, "R1 reset status", rx_status, 8'h80);
      check(fifo_valid == 1'b0, "R1 reset fifo_valid", fifo_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep: good frames contiguous, corrupted frames with idle gaps (R10)
      for (int len = 1; len <= MAXL + 8; len++) run_checked(len, 1'b0, 1'b0);
      for (int len = 1; len <= MAXL + 8; len++) run_checked(len, 1'b1, 1'b1);
      run_checked(MINL, 1'b0, 1'b1);
      run_checked(MAXL, 1'b0, 1'b1);

      // R9: post wins over a coinciding read
      build(70, 1'b0, 11);
      clear_cap();
      drive(70, 1'b0, 1'b1);
      check(rx_status == 8'h30, "R9 post beats read", rx_status, 8'h30);

      // R8: frame while status unread is dropped
      held = rx_status;
      build(80, 1'b1, 5);
      clear_cap();
      drive(80, 1'b0, 1'b0);
      check(rx_status == held, "R8 status unchanged", rx_status, held);
      check(cap_n == 0, "R8 nothing forwarded", cap_n, 0);
      do_read();
      check(rx_status == (held | 8'h80), "R9 read after drop", rx_status, held | 8'h80);

      // R10: stray bytes without a start marker
      held = rx_status;
      clear_cap();
      for (int i = 0; i < 20; i++) begin
         in_valid = 1'b1; in_data = 8'(i * 9); in_eop = (i == 19);
         @(negedge clk);
      end
      in_valid = 1'b0; in_eop = 1'b0;
      repeat (3) @(negedge clk);
      check(rx_status == held, "R10 stray bytes status", rx_status, held);
      check(cap_n == 0, "R10 stray bytes forward", cap_n, 0);

      // after stray bytes, a normal frame still checks out
      run_checked(66, 1'b0, 1'b0);
      finish_run();
   end
endmodule